// File: doc/BRIEF.md
# Write-Through Bypassing Input Buffer

This block is the input stage of one router port for a single virtual channel. Flits arrive from the link and are stored in a small queue. The flit at the head of the queue asks the switch allocator for a crossbar slot. When a grant comes back, the flit is loaded into a pipeline register that feeds the crossbar on the next cycle.

When a flit arrives and the queue is empty, it can request the switch in the same cycle it arrives. If the request is granted, the flit goes to the crossbar without being read back from storage. The arriving flit is always written through the same write path, so a bypass that is refused loses nothing. On a successful bypass the slot just written is released again, so the queue stays empty.

Each departing flit, whether it bypassed or was read from the queue, returns one credit upstream. Two counters track departures by each route. A sticky flag reports any flit that arrives while the queue is full.

Top module: `wtbuf_port`

## Requirements
- R1: After reset, out_valid, credit_ret and ovf_err are 0, both counters read 0, and sw_req is 0 while no flit is present.
- R2: sw_req is 1 exactly when the queue holds at least one flit, or when the queue is empty and in_valid is 1.
- R3: With the queue empty, in_valid at 1 and sw_grant at 1 in cycle t, out_valid is 1 in cycle t+1 carrying that cycle's in_flit, cnt_bypass rises by one, and the queue is still empty afterwards.
- R4: An arriving flit that is refused the switch in its arrival cycle is kept, and it is the next flit to leave once a grant arrives.
- R5: Flits leave in their arrival order. A flit that arrives while the queue holds flits never bypasses them, even if sw_grant is 1.
- R6: A grant while the queue holds flits sends the head flit out one cycle later and raises cnt_buffered by one.
- R7: credit_ret pulses for exactly the cycles in which out_valid is 1: one credit per departing flit, by either route.
- R8: Without sw_grant, or with sw_grant but no request pending, out_valid stays 0 in the next cycle.
- R9: The queue holds DEPTH (default 16) flits. A flit that arrives while the queue is full is dropped and sets ovf_err, which stays at 1 until reset. The stored flits are unaffected by the dropped flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Flit present on in_flit |
| in_flit | input | FLIT_W | Arriving flit |
| sw_req | output | 1 | Request for a crossbar slot |
| sw_grant | input | 1 | Grant from the switch allocator |
| out_valid | output | 1 | Flit in the crossbar stage register |
| out_flit | output | FLIT_W | Flit sent to the crossbar |
| credit_ret | output | 1 | One credit returned upstream |
| cnt_bypass | output | CNT_W | Departures that skipped the buffer read |
| cnt_buffered | output | CNT_W | Departures read from the queue |
| ovf_err | output | 1 | Sticky flag: a flit arrived while the queue was full |

## Verification
The hardest case to reach from the ports is a flit that arrives on an empty queue, is refused the switch, and is then followed by further arrivals while grants come and go. In that case the next grant must go to the stored flit and not to a newer one. The directed part of the stimulus builds this case explicitly. The random phase keeps the grant rate near the arrival rate, so the queue keeps switching between empty and holding one or two flits. The full-queue drop is forced at the end by holding off grants for DEPTH+1 arrivals. The queue is then drained to confirm that the order of the stored flits is intact.

// File: rtl/wtb_pkg.sv
package wtb_pkg;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_BYPASS = 2'd1,
    SRC_BUFFER = 2'd2
  } src_e;

  // circular pointer advance for a queue of arbitrary depth
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // occupancy update given accepted write and head advance
  function automatic int unsigned next_level(input int unsigned lvl, input bit wr, input bit adv);
    int unsigned n;
    n = lvl;
    if (wr)  n = n + 1;
    if (adv) n = n - 1;
    return n;
  endfunction

endpackage

// File: rtl/wtb_store.sv
module wtb_store #(
  parameter int FLIT_W = 32,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLIT_W-1:0] wr_data,
  input  logic              adv,
  output logic [FLIT_W-1:0] rd_data,
  output logic              empty,
  output logic              full,
  output logic [LVL_W-1:0]  level
);

  logic [FLIT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic              wr_ok;

  assign empty   = (level == '0);
  assign full    = (level == LVL_W'(DEPTH));
  assign wr_ok   = wr_en && !full;
  assign rd_data = mem[head];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[tail] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      level <= '0;
    end else begin
      if (wr_ok) tail <= PTR_W'(wtb_pkg::wrap_inc(32'(tail), DEPTH));
      if (adv)   head <= PTR_W'(wtb_pkg::wrap_inc(32'(head), DEPTH));
      level <= LVL_W'(wtb_pkg::next_level(32'(level), wr_ok, adv));
    end
  end

endmodule

// File: rtl/wtb_select.sv
module wtb_select #(
  parameter int FLIT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wtb_pkg::src_e     src,
  input  logic [FLIT_W-1:0] byp_data,
  input  logic [FLIT_W-1:0] buf_data,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_flit
);

  logic [FLIT_W-1:0] pick;

  always_comb begin
    unique case (src)
      wtb_pkg::SRC_BYPASS: pick = byp_data;
      wtb_pkg::SRC_BUFFER: pick = buf_data;
      default:             pick = out_flit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_flit  <= '0;
    end else begin
      out_valid <= (src != wtb_pkg::SRC_NONE);
      out_flit  <= pick;
    end
  end

endmodule

// File: rtl/wtb_tally.sv
module wtb_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wtb_pkg::src_e    src,
  input  logic             ovf_ev,
  output logic             credit_ret,
  output logic [CNT_W-1:0] cnt_bypass,
  output logic [CNT_W-1:0] cnt_buffered,
  output logic             ovf_err
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      credit_ret   <= 1'b0;
      cnt_bypass   <= '0;
      cnt_buffered <= '0;
      ovf_err      <= 1'b0;
    end else begin
      credit_ret <= (src != wtb_pkg::SRC_NONE);
      if (src == wtb_pkg::SRC_BYPASS) cnt_bypass   <= cnt_bypass + CNT_W'(1);
      if (src == wtb_pkg::SRC_BUFFER) cnt_buffered <= cnt_buffered + CNT_W'(1);
      if (ovf_ev) ovf_err <= 1'b1;
    end
  end

endmodule

// File: rtl/wtbuf_port.sv
module wtbuf_port #(
  parameter int FLIT_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FLIT_W-1:0] in_flit,
  output logic              sw_req,
  input  logic              sw_grant,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_flit,
  output logic              credit_ret,
  output logic [CNT_W-1:0]  cnt_bypass,
  output logic [CNT_W-1:0]  cnt_buffered,
  output logic              ovf_err
);

  logic              q_empty, q_full;
  logic [LVL_W-1:0]  q_level;
  logic [FLIT_W-1:0] q_head;
  logic              win_ev;
  logic              bypass_ev;
  logic              ovf_ev;
  wtb_pkg::src_e     src;

  assign sw_req    = q_empty ? in_valid : 1'b1;
  assign win_ev    = sw_req && sw_grant;
  assign bypass_ev = win_ev && q_empty;
  assign ovf_ev    = in_valid && q_full;

  always_comb begin
    if (!win_ev)       src = wtb_pkg::SRC_NONE;
    else if (q_empty)  src = wtb_pkg::SRC_BYPASS;
    else               src = wtb_pkg::SRC_BUFFER;
  end

  wtb_store #(.FLIT_W(FLIT_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(in_valid), .wr_data(in_flit),
    .adv(win_ev),
    .rd_data(q_head), .empty(q_empty), .full(q_full), .level(q_level)
  );

  wtb_select #(.FLIT_W(FLIT_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .src(src),
    .byp_data(in_flit), .buf_data(q_head),
    .out_valid(out_valid), .out_flit(out_flit)
  );

  wtb_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .src(src), .ovf_ev(ovf_ev),
    .credit_ret(credit_ret), .cnt_bypass(cnt_bypass),
    .cnt_buffered(cnt_buffered), .ovf_err(ovf_err)
  );

endmodule

// File: rtl/wtb_checker.sv
module wtb_checker #(
  parameter int FLIT_W = 32,
  parameter int CNT_W  = 16,
  parameter int LVL_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [FLIT_W-1:0] in_flit,
  input logic              sw_req,
  input logic              sw_grant,
  input logic              out_valid,
  input logic [FLIT_W-1:0] out_flit,
  input logic              credit_ret,
  input logic [CNT_W-1:0]  cnt_bypass,
  input logic [CNT_W-1:0]  cnt_buffered,
  input logic              ovf_err,
  input logic              empty_w,
  input logic              full_w,
  input logic              bypass_ev,
  input logic [LVL_W-1:0]  level_w
);

  a_r2_req_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_w |-> sw_req);

  a_r3_bypass_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_ev |=> out_valid && out_flit == $past(in_flit) && cnt_bypass == $past(cnt_bypass) + CNT_W'(1));

  a_r3_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_ev |=> level_w == '0);

  a_r5_no_bypass_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    !empty_w |-> !bypass_ev);

  a_r6_buffer_count: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_req && sw_grant && !empty_w) |=> out_valid && cnt_buffered == $past(cnt_buffered) + CNT_W'(1));

  a_r7_credit_matches: assert property (@(posedge clk) disable iff (!rst_n)
    credit_ret == out_valid);

  a_r8_idle_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_req && sw_grant) |=> !out_valid);

  a_r9_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full_w) |=> ovf_err);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);

endmodule

bind wtbuf_port wtb_checker #(.FLIT_W(FLIT_W), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
  .sw_req(sw_req), .sw_grant(sw_grant), .out_valid(out_valid), .out_flit(out_flit),
  .credit_ret(credit_ret), .cnt_bypass(cnt_bypass), .cnt_buffered(cnt_buffered),
  .ovf_err(ovf_err), .empty_w(q_empty), .full_w(q_full), .bypass_ev(bypass_ev),
  .level_w(q_level)
);

// File: tb/sim_wtbuf_port.sv
module sim_wtbuf_port;

  localparam int FLIT_W = 32;
  localparam int DEPTH  = 16;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [FLIT_W-1:0] in_flit = '0;
  logic              sw_grant = 1'b0;
  logic              sw_req, out_valid, credit_ret, ovf_err;
  logic [FLIT_W-1:0] out_flit;
  logic [CNT_W-1:0]  cnt_bypass, cnt_buffered;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [FLIT_W-1:0] mq[$];
  int unsigned m_byp = 0, m_buf = 0;
  bit m_err = 1'b0;

  always #2 clk = ~clk;

  wtbuf_port #(.FLIT_W(FLIT_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
    .sw_req(sw_req), .sw_grant(sw_grant), .out_valid(out_valid), .out_flit(out_flit),
    .credit_ret(credit_ret), .cnt_bypass(cnt_bypass), .cnt_buffered(cnt_buffered),
    .ovf_err(ovf_err)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_request(input bit v, input int unsigned held);
    return (held != 0) || v;
  endfunction

  task automatic step(input bit v, input logic [FLIT_W-1:0] f, input bit g, input string tag);
    bit er, dep, byp, was_full;
    logic [FLIT_W-1:0] dflit;
    dflit = '0;
    @(negedge clk);
    in_valid = v; in_flit = f; sw_grant = g;
    #1;
    er = exp_request(v, mq.size());
    check(sw_req === er, "R2 sw_req", 64'(sw_req), 64'(er));
    was_full = (mq.size() == DEPTH);
    dep = g && er;
    byp = dep && (mq.size() == 0);
    if (dep) begin
      if (byp) begin dflit = f; m_byp++; end
      else begin dflit = mq.pop_front(); m_buf++; end
    end
    if (v && !byp) begin
      if (was_full) m_err = 1'b1;
      else mq.push_back(f);
    end
    @(posedge clk); #1;
    check(out_valid === dep, "R8 out_valid", 64'(out_valid), 64'(dep));
    check(credit_ret === dep, "R7 credit_ret", 64'(credit_ret), 64'(dep));
    if (dep) check(out_flit === dflit, tag, 64'(out_flit), 64'(dflit));
    check(cnt_bypass === CNT_W'(m_byp), "R3 cnt_bypass", 64'(cnt_bypass), 64'(CNT_W'(m_byp)));
    check(cnt_buffered === CNT_W'(m_buf), "R6 cnt_buffered", 64'(cnt_buffered), 64'(CNT_W'(m_buf)));
    check(ovf_err === m_err, "R9 ovf_err", 64'(ovf_err), 64'(m_err));
  endtask

  initial begin
    int unsigned guard = 0;
    while (!finished) begin
      @(posedge clk);
      guard++;
      if (guard > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", guard);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4417));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    check(out_valid === 1'b0, "R1 out_valid", 64'(out_valid), 0);
    check(credit_ret === 1'b0, "R1 credit_ret", 64'(credit_ret), 0);
    check(ovf_err === 1'b0, "R1 ovf_err", 64'(ovf_err), 0);
    check(cnt_bypass === '0 && cnt_buffered === '0, "R1 counters", 64'({cnt_bypass, cnt_buffered}), 0);
    check(sw_req === 1'b0, "R1 sw_req", 64'(sw_req), 0);

    // R3 bypass on empty queue with grant, then idle shows the queue empty
    step(1, 32'hA0A0_0001, 1, "R3 bypass flit");
    step(0, '0, 1, "R3 nothing left");
    // R4 denied bypass, then served before a newer arrival
    step(1, 32'hB0B0_0001, 0, "R4 denied");
    step(1, 32'hB0B0_0002, 1, "R4 kept flit first");
    step(0, '0, 1, "R5 second flit");
    // R5 build a backlog, grants with arrivals must not let new flits jump
    step(1, 32'hC0C0_0001, 0, "R5 fill");
    step(1, 32'hC0C0_0002, 0, "R5 fill");
    step(1, 32'hC0C0_0003, 1, "R5 order");
    step(1, 32'hC0C0_0004, 1, "R5 order");
    step(0, '0, 1, "R6 drain");
    step(0, '0, 1, "R6 drain");
    step(0, '0, 1, "R6 drain");
    // R8 grant with nothing pending
    step(0, '0, 1, "R8 idle");

    // random phase: upstream respects credits
    for (int i = 0; i < 3000; i++) begin
      bit v, g;
      v = ($urandom % 100) < 55 && mq.size() < DEPTH;
      g = ($urandom % 100) < 60;
      step(v, $urandom, g, "R5 random order");
    end
    while (mq.size() != 0) step(0, '0, 1, "R6 random drain");

    // R9 fill to capacity, then one extra flit
    for (int i = 0; i < DEPTH; i++) step(1, 32'hD000_0000 + 32'(i), 0, "R9 fill");
    check(ovf_err === 1'b0, "R9 no error at capacity", 64'(ovf_err), 0);
    step(1, 32'hDEAD_BEEF, 0, "R9 dropped");
    step(0, '0, 0, "R9 hold");
    for (int i = 0; i < DEPTH; i++) step(0, '0, 1, "R9 stored intact");
    step(0, '0, 1, "R9 empty after drain");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule